// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C master in standard and fast mode. It divides the functional clock down to an internal sampling tick. The tick rate depends on the mode: 9.6 MHz in fast mode and 4 MHz in standard mode. It then counts ticks to form the low and high halves of each SCL period. The two phase counts come from one of two sources. They can be worked out from a target bus rate in kHz, or they can be taken as-is from two 8-bit count inputs.

Any setting that yields a prescaler or a phase count of zero or less, or a phase count above 255, is refused. A refused setting raises an error flag, and the generator then stays idle with SCL released. The high phase only counts while the sensed SCL line is high, so a slave that holds the line low stretches the clock.

Top module: `scl_timing_gen`

## Requirements
- R1: When the mode is fast, the tick comes every FCLK_KHZ/9600 clock cycles; this is the prescaler plus one, or 5 cycles with defaults. In computed mode, fast means `rate_khz` above 100. In direct mode, fast means `fast_mode`=1.
- R2: When the mode is standard, the tick comes every FCLK_KHZ/4000 clock cycles, or 12 cycles with defaults.
- R3: In computed fast mode, let T = 9600/`rate_khz` (integer division). The low count is T - T/3 - LO_TRIM and the high count is T/3 - HI_TRIM, with trims of 7 and 5 by default.
- R4: In computed standard mode, let Q = 4000/(2*`rate_khz`). The low count is Q - LO_TRIM and the high count is Q - HI_TRIM.
- R5: `cfg_err` goes high one clock after the inputs change if any of these holds: a count is 0 or less, a count is above 255, the prescaler is 0 or less, or the rate is 0 in computed mode. While it is high, `scl_out` stays 1 and `tick` stays 0.
- R6: When `cfg_direct`=1, `low_cnt` and `high_cnt` are used as the phase counts unchanged, and a zero in either one raises `cfg_err`.
- R7: While running with SCL unstretched, each low phase of `scl_out` lasts L*P clock cycles and each high phase lasts H*P clock cycles, where P is the tick spacing.
- R8: Tick counting in the high phase pauses while `scl_in` is low. A stretch of S clock edges therefore lengthens the high phase to H*P+S, and during the stretch `scl_phase` reads 2'b10. Otherwise `scl_phase` is 2'b00 in the low phase and 2'b01 in the high phase.
- R9: When `enable`=0, from the next clock on `scl_out` is 1 and `tick` is 0. Out of reset, `scl_out` is 1 and `tick` is 0.
- R10: `tick` is a single-cycle pulse, and while SCL is unstretched it repeats every P cycles across phase changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the generator |
| cfg_direct | input | 1 | 1: use count inputs, 0: derive from rate |
| fast_mode | input | 1 | Tick rate choice in direct mode (1 = fast) |
| rate_khz | input | RATE_W | Target bus rate in kHz (computed mode) |
| low_cnt | input | 8 | Low phase ticks (direct mode) |
| high_cnt | input | 8 | High phase ticks (direct mode) |
| scl_in | input | 1 | Sensed SCL bus level |
| scl_out | output | 1 | SCL drive level, 1 = released |
| tick | output | 1 | Internal sampling tick strobe |
| scl_phase | output | 2 | 00 low, 01 high, 10 high held by stretch |
| cfg_err | output | 1 | Current setting is refused |

## Verification
The SCL low and high durations are measured at several settings. Computed rates of 100 and 10 kHz exercise the standard split. Rates of 400 and 101 kHz exercise the asymmetric fast split just above the mode threshold. Two direct settings are measured, one with a fast tick and one with a standard tick. Together these separate a wrong trim, a wrong third, a wrong prescaler and a wrong mode threshold. Rates that overflow 255 or go below zero, a zero rate and a zero direct count must raise the error and hold SCL quiet. A stretched high phase and a mid-run disable confirm that counting pauses and that the line is released.

// File: rtl/scl_pkg.sv
// Shared types for the SCL timing generator.
package scl_pkg;
    typedef enum logic { PH_LOW = 1'b0, PH_HIGH = 1'b1 } scl_state_t;
    localparam logic [1:0] PHASE_LOW     = 2'b00;
    localparam logic [1:0] PHASE_HIGH    = 2'b01;
    localparam logic [1:0] PHASE_STRETCH = 2'b10;
endpackage

// File: rtl/scl_cfg_calc.sv
// Derives prescaler and phase counts from the mode and rate (or direct counts),
// validates them and registers the result. Assumes inputs are quasi-static,
// so the combinational divide has many cycles to settle before use.
module scl_cfg_calc #(
    parameter int FCLK_KHZ      = 48000,
    parameter int TICK_FAST_KHZ = 9600,
    parameter int TICK_STD_KHZ  = 4000,
    parameter int FAST_MIN_KHZ  = 100,
    parameter int LO_TRIM       = 7,
    parameter int HI_TRIM       = 5,
    parameter int RATE_W        = 11,
    parameter int PSC_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_i,
    input  logic              fast_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [7:0]        lo_i,
    input  logic [7:0]        hi_i,
    output logic [PSC_W-1:0]  psc_o,
    output logic [7:0]        lo_o,
    output logic [7:0]        hi_o,
    output logic              err_o
);
    localparam int PSC_FAST = FCLK_KHZ / TICK_FAST_KHZ - 1;
    localparam int PSC_STD  = FCLK_KHZ / TICK_STD_KHZ - 1;

    logic        is_fast;
    logic signed [31:0] rate_s, per, lo_c, hi_c, psc_c;
    logic        bad;

    // Work out the candidate counts and whether they are acceptable.
    always_comb begin
        rate_s  = $signed({{(32-RATE_W){1'b0}}, rate_i});
        is_fast = direct_i ? fast_i : (rate_s > FAST_MIN_KHZ);
        psc_c   = is_fast ? PSC_FAST : PSC_STD;
        per     = 0;
        lo_c    = 0;
        hi_c    = 0;
        if (direct_i) begin
            lo_c = $signed({24'd0, lo_i});
            hi_c = $signed({24'd0, hi_i});
        end else if (rate_s != 0) begin
            if (is_fast) begin
                per  = TICK_FAST_KHZ / rate_s;
                lo_c = per - per / 3 - LO_TRIM;
                hi_c = per / 3 - HI_TRIM;
            end else begin
                per  = TICK_STD_KHZ / (2 * rate_s);
                lo_c = per - LO_TRIM;
                hi_c = per - HI_TRIM;
            end
        end
        bad = (lo_c <= 0) || (hi_c <= 0) || (lo_c > 255) || (hi_c > 255) ||
              (psc_c <= 0) || (!direct_i && rate_s == 0);
    end

    // Register the settled configuration; reset leaves it refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_o <= '0;
            lo_o  <= '0;
            hi_o  <= '0;
            err_o <= 1'b1;
        end else begin
            psc_o <= PSC_W'(psc_c);
            lo_o  <= lo_c[7:0];
            hi_o  <= hi_c[7:0];
            err_o <= bad;
        end
    end

    // An accepted setting never carries a zero phase count (R5, R6).
    assert_no_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> (lo_o != 8'd0 && hi_o != 8'd0 && psc_o != '0));
endmodule

// File: rtl/scl_prescaler.sv
// Divides the functional clock to the sampling tick. Assumes psc_i >= 1
// whenever run_i is high. Hold pauses and rewinds the count.
module scl_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hold_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] cnt;

    assign tick_o = run_i && !hold_i && (cnt == psc_i);

    // Count up to the prescaler value and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || hold_i) cnt <= '0;
        else if (cnt == psc_i)          cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    // Ticks are single-cycle pulses (R10).
    assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/scl_phase_fsm.sv
// Alternates the SCL low and high phases, counting ticks per phase.
// Assumes lo_i and hi_i are non-zero whenever run_i is high.
module scl_phase_fsm
    import scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       scl_in_i,
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    output scl_state_t st_o
);
    logic [7:0] ph_cnt;
    logic [7:0] limit;

    assign limit = (st_o == PH_LOW) ? lo_i : hi_i;

    // Step the tick count and flip the phase at its limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            st_o   <= PH_HIGH;
            ph_cnt <= '0;
        end else if (tick_i) begin
            if (ph_cnt == limit - 8'd1) begin
                ph_cnt <= '0;
                st_o   <= (st_o == PH_LOW) ? PH_HIGH : PH_LOW;
            end else begin
                ph_cnt <= ph_cnt + 8'd1;
            end
        end
    end

    // A stretched high phase cannot end (R8).
    assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && st_o == PH_HIGH && !scl_in_i) |=> st_o == PH_HIGH);
    // Stopping releases SCL (R9).
    assert_off_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> st_o == PH_HIGH);
endmodule

// File: rtl/scl_timing_gen.sv
// SCL timing generator top: configuration, tick prescaler and phase FSM.
// Assumes scl_in is already synchronised to clk.
module scl_timing_gen
    import scl_pkg::*;
#(
    parameter int FCLK_KHZ = 48000,
    parameter int LO_TRIM  = 7,
    parameter int HI_TRIM  = 5,
    parameter int RATE_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_direct,
    input  logic              fast_mode,
    input  logic [RATE_W-1:0] rate_khz,
    input  logic [7:0]        low_cnt,
    input  logic [7:0]        high_cnt,
    input  logic              scl_in,
    output logic              scl_out,
    output logic              tick,
    output logic [1:0]        scl_phase,
    output logic              cfg_err
);
    localparam int TICK_FAST_KHZ = 9600;
    localparam int TICK_STD_KHZ  = 4000;
    localparam int PSC_MAX       = FCLK_KHZ / TICK_STD_KHZ;
    localparam int PSC_W         = (PSC_MAX < 2) ? 1 : $clog2(PSC_MAX + 1);

    logic [PSC_W-1:0] psc;
    logic [7:0]       lo_q, hi_q;
    logic             run, hold;
    scl_state_t       st;

    assign run  = enable && !cfg_err;
    assign hold = (st == PH_HIGH) && !scl_in;

    scl_cfg_calc #(
        .FCLK_KHZ(FCLK_KHZ), .TICK_FAST_KHZ(TICK_FAST_KHZ), .TICK_STD_KHZ(TICK_STD_KHZ),
        .FAST_MIN_KHZ(100), .LO_TRIM(LO_TRIM), .HI_TRIM(HI_TRIM),
        .RATE_W(RATE_W), .PSC_W(PSC_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .direct_i(cfg_direct), .fast_i(fast_mode),
        .rate_i(rate_khz), .lo_i(low_cnt), .hi_i(high_cnt),
        .psc_o(psc), .lo_o(lo_q), .hi_o(hi_q), .err_o(cfg_err)
    );

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hold_i(hold), .psc_i(psc), .tick_o(tick)
    );

    scl_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick), .scl_in_i(scl_in),
        .lo_i(lo_q), .hi_i(hi_q), .st_o(st)
    );

    assign scl_out   = (st == PH_HIGH);
    assign scl_phase = (st == PH_LOW) ? PHASE_LOW : (scl_in ? PHASE_HIGH : PHASE_STRETCH);

    // A refused setting never produces ticks (R5).
    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !tick);
    // No tick is issued while the bus is held low in the high phase (R8).
    assert_no_tick_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out && !scl_in) |-> !tick);
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, cfg_direct = 1'b0, fast_mode = 1'b0;
    logic [10:0] rate_khz = 11'd100;
    logic [7:0] low_cnt = 8'd0, high_cnt = 8'd0;
    logic scl_out, tick, cfg_err;
    logic [1:0] scl_phase;
    logic stretch_en = 1'b0;
    int   hold_left = 0;
    logic scl_in;

    int total = 0, bad = 0, cycles = 0;
    int exp_q[$];
    int run_len = 0;
    logic run_valid = 1'b0;
    logic prev_scl = 1'b1;
    logic phase_checked = 1'b0;

    localparam int PF = 48000 / 9600;
    localparam int PS = 48000 / 4000;

    assign scl_in = scl_out && (hold_left == 0);

    always #2.5 clk = ~clk;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_direct(cfg_direct),
        .fast_mode(fast_mode), .rate_khz(rate_khz), .low_cnt(low_cnt),
        .high_cnt(high_cnt), .scl_in(scl_in), .scl_out(scl_out), .tick(tick),
        .scl_phase(scl_phase), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures each complete SCL run and compares with the queue.
    always @(negedge clk) begin
        cycles++;
        if (!enable) begin
            run_valid = 1'b0;
            run_len   = 0;
        end else if (scl_out == prev_scl) begin
            run_len++;
        end else begin
            if (run_valid && exp_q.size() > 0) chk("R7/R8 phase length", run_len, exp_q.pop_front());
            run_valid = 1'b1;
            run_len   = 1;
        end
        // Stretcher: holds the bus low for 7 edges after each SCL rise.
        if (hold_left > 0) begin
            if (hold_left == 4 && !phase_checked) begin
                chk("R8 stretch phase code", int'(scl_phase), 2);
                phase_checked = 1'b1;
            end
            hold_left--;
        end else if (stretch_en && scl_out && !prev_scl) begin
            hold_left = 7;
        end
        prev_scl = scl_out;
    end

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic setup(input logic dir, input logic fm, input int rate, input int lo, input int hi);
        @(negedge clk);
        enable     = 1'b0;
        cfg_direct = dir;
        fast_mode  = fm;
        rate_khz   = 11'(rate);
        low_cnt    = 8'(lo);
        high_cnt   = 8'(hi);
        repeat (3) @(negedge clk);
    endtask

    // Driver: pushes expected durations and runs until all are observed.
    task automatic run_periods(input string req, input int lo_cyc, input int hi_cyc);
        chk({req, " accepted"}, int'(cfg_err), 0);
        exp_q.push_back(lo_cyc); exp_q.push_back(hi_cyc);
        exp_q.push_back(lo_cyc); exp_q.push_back(hi_cyc);
        enable = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic count_ticks(input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick) k++;
        end
    endtask

    task automatic refused(input string req);
        int k;
        chk({req, " error flag"}, int'(cfg_err), 1);
        enable = 1'b1;
        count_ticks(40, k);
        chk({req, " no ticks"}, k, 0);
        chk({req, " SCL released"}, int'(scl_out), 1);
        enable = 1'b0;
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset scl_out", int'(scl_out), 1);
        chk("R9 reset tick", int'(tick), 0);
        rst_n = 1'b1;

        // R1 R3: computed fast 400 kHz -> T=24, L=9, H=3
        setup(1'b0, 1'b0, 400, 0, 0);
        run_periods("R3 fast 400", 9 * PF, 3 * PF);
        // R3 boundary: 101 kHz is fast -> T=95, L=57, H=26
        setup(1'b0, 1'b0, 101, 0, 0);
        run_periods("R3 fast 101", 57 * PF, 26 * PF);
        // R2 R4: standard 100 kHz -> Q=20, L=13, H=15
        setup(1'b0, 1'b0, 100, 0, 0);
        run_periods("R4 std 100", 13 * PS, 15 * PS);
        // R4: standard 10 kHz -> Q=200, L=193, H=195
        setup(1'b0, 1'b0, 10, 0, 0);
        run_periods("R4 std 10", 193 * PS, 195 * PS);
        // R6: direct counts with fast and standard ticks
        setup(1'b1, 1'b1, 0, 20, 10);
        run_periods("R6 direct fast", 20 * PF, 10 * PF);
        setup(1'b1, 1'b0, 0, 3, 2);
        run_periods("R6 direct std", 3 * PS, 2 * PS);

        // R10: tick spacing, standard then fast, across phase changes
        setup(1'b0, 1'b0, 100, 0, 0);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        count_ticks(10 * PS * 30, k);
        chk("R10 std tick count", k, 300);
        setup(1'b0, 1'b0, 400, 0, 0);
        enable = 1'b1;
        repeat (7) @(negedge clk);
        count_ticks(PF * 100, k);
        chk("R10 fast tick count", k, 100);

        // R9: disable mid-run releases SCL and stops ticks
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 disable scl_out", int'(scl_out), 1);
        count_ticks(20, k);
        chk("R9 disable ticks", k, 0);

        // R5: refused settings
        setup(1'b0, 1'b0, 5, 0, 0);      // Q=400 -> counts above 255
        refused("R5 overflow");
        setup(1'b0, 1'b0, 1000, 0, 0);   // T=9 -> high count negative
        refused("R5 negative");
        setup(1'b0, 1'b0, 0, 0, 0);
        refused("R5 zero rate");
        setup(1'b1, 1'b1, 0, 0, 9);
        refused("R6 zero direct count");

        // R8: stretched high phase, 7 extra edges
        setup(1'b0, 1'b0, 400, 0, 0);
        stretch_en = 1'b1;
        run_periods("R8 stretch", 9 * PF, 3 * PF + 7);
        stretch_en = 1'b0;
        chk("R8 stretch phase seen", int'(phase_checked), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule